// File: doc/BRIEF.md
# Dual-Source ADC Control and Status Register

This block is the register front end of an analog-to-digital converter. Conversion requests come from two places: software writes a start bit, and a hardware or external trigger pulse sets a second start bit. The block serves one request at a time. It launches the converter core with a one-cycle start pulse and waits for that core's done pulse. It then stores the result in one of two result registers, chosen by the source that asked for the conversion.

Each source has its own end-of-conversion flag. Software clears a flag in two steps: it must first read the flag as 1 from the control/status register, and then write 0 to that bit. A combined interrupt output is driven while the interrupt enable is set and either flag is set. A low-power/stop input returns the control/status register to its reset value and abandons any conversion in flight.

The converter port has no back-pressure. `conv_start` is a one-cycle request. `conv_done` acts as a valid strobe for `conv_data`. The block is always ready for it while a conversion is in flight, and it drops any done strobe that arrives while no conversion is in flight. The CPU bus is a plain strobe bus with no wait states.

Top module: `adc_ctl_regs`

## Requirements
- R1: After reset, and on the cycle after `lp_stop` is high, the control/status register (address 0) reads 0x01. Its bit layout is: bit7 software end flag, bit6 hardware end flag, bit5 interrupt enable, bit4 software start, bit3 hardware start, bit2 busy, bit1 reads 0, bit0 reads 1.
- R2: Writing address 0 with bit4 = 1 sets the software start bit. While the block is idle, a set start bit drives `conv_start` high for one cycle. Writing bit4 = 0 has no effect on the bit.
- R3: A one-cycle `hw_trig` pulse sets the hardware start bit (bit3), which requests a conversion in the same way.
- R4: When both start bits are set while idle, the hardware request is served first. The software request stays pending in bit4 and is served after the hardware conversion completes.
- R5: Both result registers are RES_W (10) bits wide and reset to 0. On an accepted `conv_done`, `conv_data` is loaded into the software result (address 1 = upper bits, address 2 = low byte) or into the hardware result (address 3 = upper bits, address 4 = low byte). The start bit that was served then clears.
- R6: Completion of a software conversion sets bit7. Completion of a hardware conversion sets bit6.
- R7: An end flag clears only on a write of 0 to its bit that follows a read of address 0 in which the flag was 1. A write of 0 without such a read, and a write of 1, leave the flag set.
- R8: If a flag's set event and a valid clearing write happen in the same cycle, the flag stays 1.
- R9: Busy (bit2) reads 1 from the cycle after `conv_start` until `conv_done` is accepted. `conv_start` is never raised while busy.
- R10: `irq` is high exactly when bit5 and at least one of bit7 or bit6 are 1.
- R11: `lp_stop` abandons a conversion in flight. A `conv_done` that arrives while not busy changes no result register and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lp_stop | input | 1 | Low-power / module stop; synchronously returns the CSR to 0x01 |
| bus_addr | input | 3 | Register address (0 CSR, 1..4 result bytes) |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe; a CSR read arms flag clearing |
| bus_rdata | output | 8 | Read data, valid while `bus_rd` is high, 0 otherwise |
| hw_trig | input | 1 | Hardware/external trigger pulse |
| conv_start | output | 1 | One-cycle start request to the converter core |
| conv_done | input | 1 | Converter completion strobe, qualifies `conv_data` |
| conv_data | input | 10 | Conversion result |
| irq | output | 1 | End-of-conversion interrupt |

## Verification
A wrong served-source register shows on the next CSR read after completion: the result lands in the wrong result register, and the wrong end flag rises, within one cycle of `conv_done`. A wrong arm latch shows as a flag that clears on the first unarmed 0-write, or one that survives an armed 0-write, and this is visible on the very next CSR read. A stuck busy state shows within one cycle either as a second `conv_start` or as a pending start bit that never launches. An ignored-done fault shows as a changed result byte read after `lp_stop`.

// File: rtl/adc_ctl_pkg.sv
package adc_ctl_pkg;
  // CSR bit positions
  localparam int B_SEND = 7;
  localparam int B_HEND = 6;
  localparam int B_IE   = 5;
  localparam int B_SST  = 4;
  localparam int B_HST  = 3;
  localparam int B_BUSY = 2;

  // register addresses
  localparam logic [2:0] A_CSR   = 3'd0;
  localparam logic [2:0] A_SW_HI = 3'd1;
  localparam logic [2:0] A_SW_LO = 3'd2;
  localparam logic [2:0] A_HW_HI = 3'd3;
  localparam logic [2:0] A_HW_LO = 3'd4;

  localparam logic [7:0] CSR_RST = 8'h01;

  typedef enum logic {SRC_SW = 1'b0, SRC_HW = 1'b1} src_e;
endpackage

// File: rtl/adc_ctl_seq.sv
module adc_ctl_seq
  import adc_ctl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic stop,
  input  logic sw_set,
  input  logic hw_trig,
  input  logic conv_done,
  output logic sst,
  output logic hst,
  output logic busy,
  output logic conv_start,
  output logic done_sw,
  output logic done_hw
);
  logic busy_q, sst_q, hst_q;
  src_e src_q;
  logic take;

  assign take       = busy_q && conv_done;
  assign done_sw    = take && (src_q == SRC_SW);
  assign done_hw    = take && (src_q == SRC_HW);
  assign conv_start = !busy_q && (hst_q || sst_q) && !stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sst_q  <= 1'b0;
      hst_q  <= 1'b0;
      src_q  <= SRC_SW;
    end else if (stop) begin
      busy_q <= 1'b0;
      sst_q  <= 1'b0;
      hst_q  <= 1'b0;
      src_q  <= SRC_SW;
    end else begin
      if (conv_start) begin
        busy_q <= 1'b1;
        src_q  <= hst_q ? SRC_HW : SRC_SW;
      end else if (take) begin
        busy_q <= 1'b0;
      end
      sst_q <= (sst_q && !done_sw) || sw_set;
      hst_q <= (hst_q && !done_hw) || hw_trig;
    end
  end

  assign sst  = sst_q;
  assign hst  = hst_q;
  assign busy = busy_q;

  // hardware request wins when both are pending
  assert_hw_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && hst_q && sst_q && !stop) |=> (busy_q && src_q == SRC_HW));

  // a losing software request is kept
  assert_sw_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sst_q && !done_sw && !stop) |=> sst_q);

  // start is a single pulse, followed by busy
  assert_one_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> (busy_q && !conv_start));
endmodule

// File: rtl/adc_ctl_endflag.sv
module adc_ctl_endflag (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic set,
  input  logic rd_csr,
  input  logic wr_csr,
  input  logic wr_bit,
  output logic flag
);
  logic flag_q, armed_q;
  logic clear_ok;

  assign clear_ok = wr_csr && !wr_bit && armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (clr) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (set)           flag_q <= 1'b1;
      else if (clear_ok) flag_q <= 1'b0;

      if (set || clear_ok)        armed_q <= 1'b0;
      else if (rd_csr && flag_q)  armed_q <= 1'b1;
    end
  end

  assign flag = flag_q;

  assert_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (set && !clr) |=> flag_q);

  assert_keep_unarmed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !armed_q && !clr) |=> flag_q);

  assert_armed_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && armed_q && wr_csr && !wr_bit && !set && !clr) |=> !flag_q);

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (set && wr_csr && !wr_bit && !clr) |=> flag_q);
endmodule

// File: rtl/adc_ctl_results.sv
module adc_ctl_results #(
  parameter int RES_W = 10,
  parameter int NSRC  = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NSRC-1:0]            load,
  input  logic [RES_W-1:0]           din,
  output logic [NSRC-1:0][RES_W-1:0] res
);
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic [RES_W-1:0] r_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       r_q <= '0;
      else if (load[i]) r_q <= din;
    end
    assign res[i] = r_q;
  end

  // at most one source completes per cycle
  assert_single_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load));
endmodule

// File: rtl/adc_ctl_regs.sv
module adc_ctl_regs
  import adc_ctl_pkg::*;
#(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lp_stop,
  input  logic [2:0]       bus_addr,
  input  logic             bus_wr,
  input  logic [7:0]       bus_wdata,
  input  logic             bus_rd,
  output logic [7:0]       bus_rdata,
  input  logic             hw_trig,
  output logic             conv_start,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_data,
  output logic             irq
);
  localparam int HI_W = RES_W - 8;
  localparam int NSRC = 2;
  localparam int I_SW = 0;
  localparam int I_HW = 1;

  logic wr_csr, rd_csr, sw_set;
  logic sst, hst, busy, done_sw, done_hw;
  logic send, hend, ie_q;
  logic [NSRC-1:0][RES_W-1:0] res;
  logic [7:0] csr_val, mux;
  logic unused_wbits;

  assign wr_csr = bus_wr && (bus_addr == A_CSR);
  assign rd_csr = bus_rd && (bus_addr == A_CSR);
  assign sw_set = wr_csr && bus_wdata[B_SST];
  assign unused_wbits = ^{bus_wdata[B_HST], bus_wdata[B_BUSY], bus_wdata[1:0]};

  adc_ctl_seq u_seq (
    .clk(clk), .rst_n(rst_n), .stop(lp_stop), .sw_set(sw_set), .hw_trig(hw_trig),
    .conv_done(conv_done), .sst(sst), .hst(hst), .busy(busy),
    .conv_start(conv_start), .done_sw(done_sw), .done_hw(done_hw)
  );

  adc_ctl_endflag u_send (
    .clk(clk), .rst_n(rst_n), .clr(lp_stop), .set(done_sw), .rd_csr(rd_csr),
    .wr_csr(wr_csr), .wr_bit(bus_wdata[B_SEND]), .flag(send)
  );

  adc_ctl_endflag u_hend (
    .clk(clk), .rst_n(rst_n), .clr(lp_stop), .set(done_hw), .rd_csr(rd_csr),
    .wr_csr(wr_csr), .wr_bit(bus_wdata[B_HEND]), .flag(hend)
  );

  adc_ctl_results #(.RES_W(RES_W), .NSRC(NSRC)) u_res (
    .clk(clk), .rst_n(rst_n), .load({done_hw, done_sw}), .din(conv_data), .res(res)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ie_q <= 1'b0;
    else if (lp_stop) ie_q <= 1'b0;
    else if (wr_csr) ie_q <= bus_wdata[B_IE];
  end

  assign csr_val = {send, hend, ie_q, sst, hst, busy, 1'b0, 1'b1};

  always_comb begin
    case (bus_addr)
      A_CSR:   mux = csr_val;
      A_SW_HI: mux = {{(8-HI_W){1'b0}}, res[I_SW][RES_W-1:8]};
      A_SW_LO: mux = res[I_SW][7:0];
      A_HW_HI: mux = {{(8-HI_W){1'b0}}, res[I_HW][RES_W-1:8]};
      A_HW_LO: mux = res[I_HW][7:0];
      default: mux = 8'h00;
    endcase
  end

  assign bus_rdata = bus_rd ? mux : 8'h00;
  assign irq = ie_q && (send || hend);

  assert_stop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    lp_stop |=> (csr_val == CSR_RST));

  assert_idle_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !busy) |=> ($stable(res) && $stable(send) && $stable(hend)));
endmodule

// File: tb/tb_adc_ctl_regs.sv
module tb_adc_ctl_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lp_stop = 1'b0;
  logic [2:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic hw_trig = 1'b0;
  logic conv_start, irq;
  logic conv_done;
  logic [9:0] conv_data;

  // converter model and manual override
  logic model_on = 1'b1;
  logic m_done = 1'b0, d_done = 1'b0;
  logic [9:0] m_val = '0, d_data = '0;
  logic [9:0] m_data = '0;
  assign conv_done = m_done | d_done;
  assign conv_data = model_on ? m_data : d_data;

  int total = 0, bad = 0;

  always #2 clk = ~clk;  // 250 MHz

  adc_ctl_regs dut (
    .clk(clk), .rst_n(rst_n), .lp_stop(lp_stop), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .hw_trig(hw_trig), .conv_start(conv_start), .conv_done(conv_done),
    .conv_data(conv_data), .irq(irq)
  );

  // converter: done two negedges after seeing start, value auto-increments
  initial begin
    forever begin
      @(negedge clk);
      m_done = 1'b0;
      if (model_on && conv_start) begin
        repeat (2) @(negedge clk);
        m_done = 1'b1;
        m_data = m_val;
        m_val  = m_val + 10'd1;
      end
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // all tasks start and end on a negedge
  task automatic wr(input logic [7:0] d);
    bus_addr = 3'd0; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string req);
    bus_addr = a; bus_rd = 1'b1;
    #1 check(req, bus_rdata, exp);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse_done(input logic [9:0] d);
    d_done = 1'b1; d_data = d;
    @(negedge clk);
    d_done = 1'b0;
  endtask

  // op codes: 0 write CSR, 1 read+check, 2 trigger, 3 trigger+write, 4 wait, 5 set model value, 6 check irq
  // entry: {op[3], addr[3], val[10], exp[8], req[4]}
  localparam int NV = 51;
  localparam logic [27:0] VEC [NV] = '{
    {3'd1,3'd0,10'h000,8'h01,4'd1},   // R1 reset value
    {3'd1,3'd1,10'h000,8'h00,4'd5},   // R5 results reset
    {3'd1,3'd2,10'h000,8'h00,4'd5},
    {3'd1,3'd3,10'h000,8'h00,4'd5},
    {3'd1,3'd4,10'h000,8'h00,4'd5},
    {3'd0,3'd0,10'h020,8'h00,4'd10},
    {3'd1,3'd0,10'h000,8'h21,4'd10},  // R10 enable alone
    {3'd6,3'd0,10'h000,8'h00,4'd10},
    {3'd5,3'd0,10'h2B7,8'h00,4'd2},
    {3'd0,3'd0,10'h030,8'h00,4'd2},
    {3'd1,3'd0,10'h000,8'h31,4'd2},   // R2 start bit seen
    {3'd4,3'd0,10'd6,  8'h00,4'd2},
    {3'd1,3'd0,10'h000,8'hA1,4'd6},   // R6 software end
    {3'd1,3'd2,10'h000,8'hB7,4'd5},
    {3'd1,3'd1,10'h000,8'h02,4'd5},
    {3'd6,3'd0,10'h000,8'h01,4'd10},
    {3'd0,3'd0,10'h020,8'h00,4'd7},
    {3'd1,3'd0,10'h000,8'h21,4'd7},   // R7 armed clear
    {3'd6,3'd0,10'h000,8'h00,4'd10},
    {3'd5,3'd0,10'h155,8'h00,4'd7},
    {3'd0,3'd0,10'h030,8'h00,4'd7},
    {3'd4,3'd0,10'd6,  8'h00,4'd7},
    {3'd0,3'd0,10'h020,8'h00,4'd7},   // 0 without read
    {3'd1,3'd0,10'h000,8'hA1,4'd7},
    {3'd0,3'd0,10'h0A0,8'h00,4'd7},   // writing 1
    {3'd1,3'd0,10'h000,8'hA1,4'd7},
    {3'd0,3'd0,10'h020,8'h00,4'd7},
    {3'd1,3'd0,10'h000,8'h21,4'd7},
    {3'd1,3'd2,10'h000,8'h55,4'd5},
    {3'd1,3'd1,10'h000,8'h01,4'd5},
    {3'd5,3'd0,10'h3C4,8'h00,4'd3},
    {3'd2,3'd0,10'h000,8'h00,4'd3},
    {3'd1,3'd0,10'h000,8'h29,4'd3},   // R3 hardware start bit
    {3'd4,3'd0,10'd6,  8'h00,4'd3},
    {3'd1,3'd0,10'h000,8'h61,4'd6},   // R6 hardware end
    {3'd1,3'd3,10'h000,8'h03,4'd5},
    {3'd1,3'd4,10'h000,8'hC4,4'd5},
    {3'd0,3'd0,10'h020,8'h00,4'd7},
    {3'd1,3'd0,10'h000,8'h21,4'd7},
    {3'd5,3'd0,10'h100,8'h00,4'd4},
    {3'd3,3'd0,10'h030,8'h00,4'd4},
    {3'd1,3'd0,10'h000,8'h39,4'd4},   // R4 both pending
    {3'd1,3'd0,10'h000,8'h3D,4'd9},   // R9 busy
    {3'd4,3'd0,10'd12, 8'h00,4'd4},
    {3'd1,3'd0,10'h000,8'hE1,4'd4},
    {3'd1,3'd3,10'h000,8'h01,4'd4},   // hw got first value
    {3'd1,3'd4,10'h000,8'h00,4'd4},
    {3'd1,3'd1,10'h000,8'h01,4'd4},   // sw got second value
    {3'd1,3'd2,10'h000,8'h01,4'd4},
    {3'd0,3'd0,10'h020,8'h00,4'd7},
    {3'd1,3'd0,10'h000,8'h21,4'd7}
  };

  task automatic finish_run;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    total++; bad++;
    $display("FAIL watchdog: got hang expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      logic [2:0] op, a; logic [9:0] v; logic [7:0] e; string rq;
      {op, a, v, e} = VEC[i][27:4];
      rq = $sformatf("R%0d", VEC[i][3:0]);
      case (op)
        3'd0: wr(v[7:0]);
        3'd1: rd(a, e, rq);
        3'd2: begin hw_trig = 1'b1; @(negedge clk); hw_trig = 1'b0; end
        3'd3: begin hw_trig = 1'b1; wr(v[7:0]); hw_trig = 1'b0; end
        3'd4: repeat (int'(v)) @(negedge clk);
        3'd5: m_val = v;
        default: begin #1 check(rq, {7'd0, irq}, e); end
      endcase
    end

    // directed: set wins over clear (R8), manual converter
    model_on = 1'b0;
    wr(8'h30);
    @(negedge clk);
    pulse_done(10'h011);
    rd(3'd0, 8'hA1, "R6");
    wr(8'hB0);                     // bit7=1 keeps flag, starts sw
    @(negedge clk);
    bus_addr = 3'd0; bus_wdata = 8'h20; bus_wr = 1'b1;
    d_done = 1'b1; d_data = 10'h022;
    @(negedge clk);
    bus_wr = 1'b0; d_done = 1'b0;
    rd(3'd0, 8'hA1, "R8");
    rd(3'd2, 8'h22, "R5");
    wr(8'h20);
    rd(3'd0, 8'h21, "R7");

    // directed: stop aborts, late done ignored (R11, R1)
    wr(8'h30);
    @(negedge clk);
    lp_stop = 1'b1;
    @(negedge clk);
    lp_stop = 1'b0;
    rd(3'd0, 8'h01, "R1");
    #1 check("R9", {7'd0, conv_start}, 8'h00);
    pulse_done(10'h3FF);
    rd(3'd2, 8'h22, "R11");
    rd(3'd1, 8'h00, "R11");
    rd(3'd0, 8'h01, "R11");

    // directed: flag without enable gives no interrupt (R10)
    wr(8'h10);
    @(negedge clk);
    pulse_done(10'h2AA);
    rd(3'd0, 8'h81, "R6");
    #1 check("R10", {7'd0, irq}, 8'h00);
    wr(8'h20);
    rd(3'd0, 8'h21, "R7");
    #1 check("R10", {7'd0, irq}, 8'h00);

    finish_run();
  end
endmodule